// File: doc/BRIEF.md
# Audio Interrupt Status Collector (Second Level)

This block gathers the interrupt events of an audio subsystem into one second-level status word. There are six DMA bus masters, a codec interrupt path (serial or GPIO, each with its own enable) and an I/O trap. Each event sets a sticky bit. Any set bit is reported upward as one registered summary line, which feeds a top-level status register. Decoding I/O traps into their third-level detail happens outside this block.

Software reads the word through a small read port at two decoded addresses. A read at the primary address returns the bits and clears every bit whose source is no longer active. A read at the mirror address returns the same bits and leaves them untouched. A DMA master's bit cannot be cleared while that master's end-of-page flag is still high. Software must first drop the flag and then read the primary address again.

Top module: `audio_irq_collector`

## Requirements
- R1: After reset the status word is 0x0000, `rdData` is 0 and `summaryIrq` is 0.
- R2: In the status word, bit 0 is the I/O trap and bit 1 is the codec interrupt. Bits 2 to 7 are DMA masters 0 to 5 in order. Bits 15:8 always read as 0.
- R3: A master's bit is set by a rising edge of its `eopFlag` bit that is sampled while its `mstEnable` bit is 1. A rise while the master is disabled sets nothing. A flag held high that was later enabled also sets nothing.
- R4: Bit 1 is set in any cycle where (`codecSerIrq` AND `codecSerEn`) OR (`codecGpioIrq` AND `codecGpioEn`) is 1.
- R5: A one-cycle `ioTrapPulse` sets bit 0.
- R6: A read strobe at the primary address (`rdAddr` = 0) loads the current word onto `rdData` at that clock edge. At the same edge it clears every bit whose source is inactive. The source of a master bit is its `eopFlag`, the source of bit 1 is the enabled codec condition, and the source of bit 0 is `ioTrapPulse`.
- R7: A master's bit stays set across primary reads for as long as that master's `eopFlag` bit is 1.
- R8: An event in the same cycle as a primary read keeps its bit set.
- R9: A read strobe at the mirror address (`rdAddr` = 2) loads the word onto `rdData` and clears nothing.
- R10: `summaryIrq` equals the OR of status bits 7:0 as they were one cycle earlier.
- R11: A read strobe at any other address loads 0 onto `rdData` and leaves the status unchanged. Without a strobe, `rdData` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mstEnable | input | 6 | Per-master event enable |
| eopFlag | input | 6 | Per-master end-of-page flag |
| codecSerIrq | input | 1 | Codec serial interrupt level |
| codecSerEn | input | 1 | Enable for codec serial interrupt |
| codecGpioIrq | input | 1 | Codec GPIO interrupt level |
| codecGpioEn | input | 1 | Enable for codec GPIO interrupt |
| ioTrapPulse | input | 1 | One-cycle I/O trap event |
| rdAddr | input | 2 | Read address |
| rdStrobe | input | 1 | Read strobe |
| rdData | output | 16 | Registered read data |
| summaryIrq | output | 1 | Registered summary to the top level |

## Verification
The assertions check the following on every cycle:
- reserved bits stay zero;
- a master bit never drops while its flag is high;
- a trap pulse always leaves bit 0 set;
- no bit falls without a primary read;
- a mirror read never lowers a bit;
- unmapped reads return zero;
- the summary tracks the previous word.

Only the bench's scenarios can show the following:
- which bit each source maps to;
- that a disabled master or a flag that was already high produces nothing;
- the codec enable truth table;
- that an event coinciding with a clearing read survives.

// File: rtl/audio_irq_pkg.sv
package audio_irq_pkg;
  // Strobes from read control to the status datapath
  typedef struct packed {
    logic capture;    // load rdData this cycle
    logic clearReq;   // clearing read of the status word
    logic selStatus;  // address maps onto the status word
  } rdCtl_t;
endpackage

// File: rtl/audio_irq_ctrl.sv
module audio_irq_ctrl
  import audio_irq_pkg::*;
#(
  parameter int ADDR_W       = 2,
  parameter int ADDR_PRIMARY = 0,
  parameter int ADDR_MIRROR  = 2
) (
  input  logic              rdStrobe,
  input  logic [ADDR_W-1:0] rdAddr,
  output rdCtl_t            ctl
);
  localparam logic [ADDR_W-1:0] PRI = ADDR_W'(ADDR_PRIMARY);
  localparam logic [ADDR_W-1:0] MIR = ADDR_W'(ADDR_MIRROR);

  logic hitPrimary;
  logic hitMirror;

  always_comb begin
    hitPrimary    = (rdAddr == PRI);
    hitMirror     = (rdAddr == MIR);
    ctl.capture   = rdStrobe;
    ctl.clearReq  = rdStrobe & hitPrimary;
    ctl.selStatus = hitPrimary | hitMirror;
  end
endmodule

// File: rtl/audio_irq_srcgen.sv
module audio_irq_srcgen #(
  parameter int NUM_MASTERS = 6,
  localparam int SRC_W      = NUM_MASTERS + 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_MASTERS-1:0] mstEnable,
  input  logic [NUM_MASTERS-1:0] eopFlag,
  input  logic                   codecSerIrq,
  input  logic                   codecSerEn,
  input  logic                   codecGpioIrq,
  input  logic                   codecGpioEn,
  input  logic                   ioTrapPulse,
  output logic [SRC_W-1:0]       setVec,
  output logic [SRC_W-1:0]       holdVec
);
  logic [NUM_MASTERS-1:0] eopPrev;
  logic                   codecActive;

  always_ff @(posedge clk) begin
    if (!rstN) eopPrev <= '0;
    else       eopPrev <= eopFlag;
  end

  always_comb begin
    codecActive = (codecSerIrq & codecSerEn) | (codecGpioIrq & codecGpioEn);
    setVec[0]   = ioTrapPulse;
    holdVec[0]  = ioTrapPulse;
    setVec[1]   = codecActive;
    holdVec[1]  = codecActive;
  end

  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_master
    // rising end-of-page while enabled raises the event
    assign setVec[m+2]  = mstEnable[m] & eopFlag[m] & ~eopPrev[m];
    // the flag itself blocks clearing
    assign holdVec[m+2] = eopFlag[m];
  end
endmodule

// File: rtl/audio_irq_datapath.sv
module audio_irq_datapath
  import audio_irq_pkg::*;
#(
  parameter int SRC_W  = 8,
  parameter int DATA_W = 16,
  localparam int PAD_W = DATA_W - SRC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdCtl_t            ctl,
  input  logic [SRC_W-1:0]  setVec,
  input  logic [SRC_W-1:0]  holdVec,
  output logic [SRC_W-1:0]  statusQ,
  output logic [DATA_W-1:0] rdData,
  output logic              summaryIrq
);
  logic [SRC_W-1:0]  clearMask;
  logic [SRC_W-1:0]  statusNext;
  logic [DATA_W-1:0] readWord;

  always_comb begin
    clearMask  = ctl.clearReq ? ~holdVec : '0;
    statusNext = setVec | (statusQ & ~clearMask);
    readWord   = ctl.selStatus ? {{PAD_W{1'b0}}, statusQ} : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ    <= '0;
      rdData     <= '0;
      summaryIrq <= 1'b0;
    end else begin
      statusQ    <= statusNext;
      summaryIrq <= |statusQ;
      if (ctl.capture) rdData <= readWord;
    end
  end
endmodule

// File: rtl/audio_irq_collector.sv
module audio_irq_collector
  import audio_irq_pkg::*;
#(
  parameter int NUM_MASTERS  = 6,
  parameter int DATA_W       = 16,
  parameter int ADDR_W       = 2,
  parameter int ADDR_PRIMARY = 0,
  parameter int ADDR_MIRROR  = 2,
  localparam int SRC_W       = NUM_MASTERS + 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_MASTERS-1:0] mstEnable,
  input  logic [NUM_MASTERS-1:0] eopFlag,
  input  logic                   codecSerIrq,
  input  logic                   codecSerEn,
  input  logic                   codecGpioIrq,
  input  logic                   codecGpioEn,
  input  logic                   ioTrapPulse,
  input  logic [ADDR_W-1:0]      rdAddr,
  input  logic                   rdStrobe,
  output logic [DATA_W-1:0]      rdData,
  output logic                   summaryIrq
);
  rdCtl_t           rdCtl;
  logic [SRC_W-1:0] setVec;
  logic [SRC_W-1:0] holdVec;
  logic [SRC_W-1:0] statusWord;

  audio_irq_ctrl #(
    .ADDR_W(ADDR_W), .ADDR_PRIMARY(ADDR_PRIMARY), .ADDR_MIRROR(ADDR_MIRROR)
  ) u_ctrl (
    .rdStrobe(rdStrobe), .rdAddr(rdAddr), .ctl(rdCtl)
  );

  audio_irq_srcgen #(.NUM_MASTERS(NUM_MASTERS)) u_src (
    .clk(clk), .rstN(rstN), .mstEnable(mstEnable), .eopFlag(eopFlag),
    .codecSerIrq(codecSerIrq), .codecSerEn(codecSerEn),
    .codecGpioIrq(codecGpioIrq), .codecGpioEn(codecGpioEn),
    .ioTrapPulse(ioTrapPulse), .setVec(setVec), .holdVec(holdVec)
  );

  audio_irq_datapath #(.SRC_W(SRC_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(rdCtl), .setVec(setVec), .holdVec(holdVec),
    .statusQ(statusWord), .rdData(rdData), .summaryIrq(summaryIrq)
  );
endmodule

// File: rtl/audio_irq_collector_chk.sv
module audio_irq_collector_chk #(
  parameter int NUM_MASTERS  = 6,
  parameter int DATA_W       = 16,
  parameter int ADDR_W       = 2,
  parameter int ADDR_PRIMARY = 0,
  parameter int ADDR_MIRROR  = 2,
  localparam int SRC_W       = NUM_MASTERS + 2
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   rdStrobe,
  input logic [ADDR_W-1:0]      rdAddr,
  input logic [NUM_MASTERS-1:0] eopFlag,
  input logic                   ioTrapPulse,
  input logic [SRC_W-1:0]       statusQ,
  input logic [DATA_W-1:0]      rdData,
  input logic                   summaryIrq
);
  localparam logic [ADDR_W-1:0] PRI = ADDR_W'(ADDR_PRIMARY);
  localparam logic [ADDR_W-1:0] MIR = ADDR_W'(ADDR_MIRROR);

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    rdData[DATA_W-1:SRC_W] == '0);

  assert_trap_sets_R5: assert property (@(posedge clk) disable iff (!rstN)
    ioTrapPulse |=> statusQ[0]);

  assert_no_fall_without_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(rdStrobe && rdAddr == PRI) |=> (($past(statusQ) & ~statusQ) == '0));

  assert_mirror_keeps_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && rdAddr == MIR) |=> (($past(statusQ) & ~statusQ) == '0));

  assert_summary_delay_R10: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> summaryIrq == (|$past(statusQ)));

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && rdAddr != PRI && rdAddr != MIR) |=> rdData == '0);

  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_hold
    assert_master_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
      (statusQ[m+2] && eopFlag[m]) |=> statusQ[m+2]);
  end
endmodule

bind audio_irq_collector audio_irq_collector_chk #(
  .NUM_MASTERS(NUM_MASTERS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .ADDR_PRIMARY(ADDR_PRIMARY), .ADDR_MIRROR(ADDR_MIRROR)
) u_chk (
  .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .rdAddr(rdAddr),
  .eopFlag(eopFlag), .ioTrapPulse(ioTrapPulse), .statusQ(statusWord),
  .rdData(rdData), .summaryIrq(summaryIrq)
);

// File: tb/audio_irq_collector_tb.sv
module audio_irq_collector_tb;
  localparam logic [1:0] PRI = 2'd0;
  localparam logic [1:0] MIR = 2'd2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  mstEnable = '0;
  logic [5:0]  eopFlag = '0;
  logic        codecSerIrq = 0, codecSerEn = 0, codecGpioIrq = 0, codecGpioEn = 0;
  logic        ioTrapPulse = 0;
  logic [1:0]  rdAddr = '0;
  logic        rdStrobe = 0;
  logic [15:0] rdData;
  logic        summaryIrq;

  int vectors = 0;
  int misses = 0;
  logic [15:0] d;

  always #10 clk = ~clk;

  audio_irq_collector u_dut (
    .clk(clk), .rstN(rstN), .mstEnable(mstEnable), .eopFlag(eopFlag),
    .codecSerIrq(codecSerIrq), .codecSerEn(codecSerEn),
    .codecGpioIrq(codecGpioIrq), .codecGpioEn(codecGpioEn),
    .ioTrapPulse(ioTrapPulse), .rdAddr(rdAddr), .rdStrobe(rdStrobe),
    .rdData(rdData), .summaryIrq(summaryIrq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] data);
    rdAddr = a;
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
    data = rdData;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    chk("R1 rdData", rdData, 16'h0);
    chk("R1 summary", 16'(summaryIrq), 16'h0);
    rstN = 1'b1;
    rd(PRI, d); chk("R1 status", d, 16'h0);

    // masters, enabled and disabled
    for (int i = 0; i < 6; i++) begin
      for (int en = 0; en < 2; en++) begin
        logic [15:0] exp;
        exp = (en != 0) ? (16'h1 << (i + 2)) : 16'h0;
        mstEnable = (en != 0) ? (6'h1 << i) : 6'h0;
        eopFlag[i] = 1'b1;
        cyc();
        rd(MIR, d); chk("R3 master event", d, exp);
        chk("R10 summary", 16'(summaryIrq), 16'(en));
        rd(PRI, d); chk("R6 primary value", d, exp);
        rd(MIR, d); chk("R7 held while flag high", d, exp);
        eopFlag[i] = 1'b0;
        mstEnable = '0;
        cyc();
        rd(PRI, d); chk("R6 primary before clear", d, exp);
        rd(MIR, d); chk("R6 cleared", d, 16'h0);
        chk("R10 summary low", 16'(summaryIrq), 16'h0);
      end
    end

    // flag already high when enabled: no event
    eopFlag[0] = 1'b1; cyc();
    mstEnable[0] = 1'b1; cyc(); cyc();
    rd(MIR, d); chk("R3 no edge no event", d, 16'h0);
    eopFlag = '0; mstEnable = '0; cyc();

    // codec enable truth table
    for (int k = 0; k < 16; k++) begin
      logic [15:0] exp;
      {codecSerIrq, codecSerEn, codecGpioIrq, codecGpioEn} = 4'(k);
      exp = 16'(((k >> 3) & (k >> 2) & 1) | ((k >> 1) & k & 1)) << 1;
      cyc();
      rd(MIR, d); chk("R4 codec bit", d, exp);
      {codecSerIrq, codecSerEn, codecGpioIrq, codecGpioEn} = 4'h0;
      rd(PRI, d);
      rd(MIR, d); chk("R6 codec cleared", d, 16'h0);
    end

    // trap and summary timing
    ioTrapPulse = 1'b1; cyc(); ioTrapPulse = 1'b0;
    chk("R10 summary not yet", 16'(summaryIrq), 16'h0);
    cyc();
    chk("R10 summary next cycle", 16'(summaryIrq), 16'h1);
    rd(MIR, d); chk("R5 trap bit", d, 16'h1);
    rd(PRI, d); chk("R6 trap read", d, 16'h1);
    rd(MIR, d); chk("R6 trap cleared", d, 16'h0);

    // event colliding with clearing read
    ioTrapPulse = 1'b1; cyc();
    rdAddr = PRI; rdStrobe = 1'b1; cyc();
    rdStrobe = 1'b0; ioTrapPulse = 1'b0;
    chk("R8 read value", rdData, 16'h1);
    rd(MIR, d); chk("R8 event wins", d, 16'h1);

    // unmapped addresses
    rd(2'd1, d); chk("R11 addr1 zero", d, 16'h0);
    rd(2'd3, d); chk("R11 addr3 zero", d, 16'h0);
    cyc(); chk("R11 rdData holds", rdData, 16'h0);
    rd(MIR, d); chk("R11 status kept", d, 16'h1);
    rd(PRI, d);
    rd(MIR, d); chk("R6 cleared after collision", d, 16'h0);

    // all masters together, layout and reserved bits
    mstEnable = 6'h3F; eopFlag = 6'h3F; cyc();
    rd(MIR, d); chk("R2 all masters", d, 16'h00FC);
    eopFlag = '0; mstEnable = '0;
    rd(PRI, d); chk("R2 primary all", d, 16'h00FC);
    rd(MIR, d); chk("R6 all cleared", d, 16'h0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule